// File: doc/BRIEF.md
# Serial Transmitter with Deferred Disable and Line Break

The block sends bytes one at a time on a single serial output. Each byte goes out in a fixed frame: one low start bit, eight data bits with the least significant bit first, and one high stop bit. A parent block writes a byte into a one-entry holding register. The transmitter starts a frame from that register on a baud tick, and each following bit lasts one baud-tick period. The tick comes from outside the block.

Two controls sit beside the data path. The first is a disable request, used for software flow control. It never cuts a frame short: the frame in progress finishes, then no new frame starts, and a sticky status flag (with a matching interrupt) reports that the transmitter has really stopped. A byte left in the holding register stays there and goes out once the request is withdrawn.

The second control is a break request. It forces the output low in the same cycle and holds it low for as long as the request stays up. A break raised in the middle of a frame abandons that frame. The clean way to send a break is to raise the disable request, wait for the status flag, and only then raise the break. When the break is released, the line goes high and stays high for at least one full bit period before the next start bit.

Top module: `uart_brk_tx`

## Requirements
- R1: Frame format. The line idles high (1). A frame starts on a baud tick with a start bit of 0. The next eight ticks each present one data bit, bit 0 first. The tick after those presents a stop bit of 1. Each bit lasts from one tick to the next.
- R2: `busy` is 1 from the tick that starts a frame until the tick that ends its stop bit, and 0 otherwise.
- R3: While `tx_dis` is 1, a frame already in progress completes unchanged and no new frame starts.
- R4: `dis_sts` becomes 1 once `tx_dis` is 1 and no frame is in progress, within two clock cycles of the frame's last tick. `dis_irq` equals `dis_sts`.
- R5: A byte held while `tx_dis` is 1 is kept (`hold_full` stays 1). When `tx_dis` returns to 0, the next tick starts a frame with that byte.
- R6: A one-cycle pulse on `dis_clr` clears `dis_sts`. The flag does not set again until a new disable episode, that is, until `tx_dis` has gone to 0 and back to 1. Dropping `tx_dis` also clears the flag.
- R7: While `brk_en` is 1, `tx_line` is 0 from the same cycle onward, whatever the transmitter state.
- R8: `brk_en` raised during a frame abandons that frame: `busy` is 0 one clock later, and the abandoned byte is never resumed.
- R9: After `brk_en` falls, `tx_line` is 1 from the next clock. The first baud tick after the release starts no frame; the earliest start is on the second tick.
- R10: `wr_en` loads `wr_data` only when `hold_full` is 0. A write while the register is full is ignored and leaves the held byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| brk_en | input | 1 | Hold the line at the break (low) level |
| tx_dis | input | 1 | Request to stop starting frames |
| dis_clr | input | 1 | Write-one pulse that clears the disabled flag |
| tx_line | output | 1 | Serial output |
| busy | output | 1 | A frame is being sent |
| hold_full | output | 1 | The holding register holds an unsent byte |
| dis_sts | output | 1 | Sticky flag: the disable has taken effect |
| dis_irq | output | 1 | Interrupt, high while `dis_sts` is set |

## Verification
A wrong bit counter or shift value shows on `tx_line` as a misplaced or missing bit within one tick period, so every bit of every frame is sampled right after its tick. A state machine that does not honour the disable or gap rules starts a start bit too early, and this is visible on the very tick where the start would fall. A status or holding register that loses or re-arms its value shows up one or two clocks after the causing event, either on `dis_sts` and `hold_full` or in the byte carried by the next frame.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_BRK  = 2'd2,
        ST_GAP  = 2'd3
    } tx_st_e;
endpackage

// File: rtl/uart_brk_hold.sv
module uart_brk_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hq, hd;

    always_comb begin
        hd = hq;
        if (take) begin
            hd.full = 1'b0;
        end
        if (wr_en && !hq.full) begin
            hd.full = 1'b1;
            hd.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hq <= '0;
        end else begin
            hq <= hd;
        end
    end

    assign full = hq.full;
    assign data = hq.data;

    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (hq.full && wr_en && !take) |=> $stable(hq.data)); // R10
endmodule

// File: rtl/uart_brk_dis.sv
module uart_brk_dis (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_dis,
    input  logic quiet,
    input  logic clr,
    output logic sts
);
    typedef struct packed {
        logic sts;
        logic seen;
    } dis_t;

    dis_t sq, sd;

    always_comb begin
        sd = sq;
        if (!tx_dis) begin
            sd.sts  = 1'b0;
            sd.seen = 1'b0;
        end else if (quiet && !sq.seen) begin
            sd.sts  = 1'b1;
            sd.seen = 1'b1;
        end else if (clr) begin
            sd.sts = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq <= '0;
        end else begin
            sq <= sd;
        end
    end

    assign sts = sq.sts;

    AST_STS_ONLY_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sq.sts) |-> ($past(tx_dis) && $past(quiet))); // R4
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              brk_en,
    input  logic              tx_dis,
    input  logic              dis_clr,
    output logic              tx_line,
    output logic              busy,
    output logic              hold_full,
    output logic              dis_sts,
    output logic              dis_irq
);
    import uart_brk_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W + 1);

    typedef struct packed {
        tx_st_e           st;
        logic [CNT_W-1:0] cnt;
        logic [DATA_W:0]  sh;
        logic             line;
    } tx_t;

    tx_t              rq, rd;
    logic             take;
    logic             start_ok;
    logic [DATA_W-1:0] hold_data;

    uart_brk_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_brk_dis u_dis (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_dis (tx_dis),
        .quiet  (rq.st != ST_SEND),
        .clr    (dis_clr),
        .sts    (dis_sts)
    );

    assign start_ok = baud_tick && hold_full && !tx_dis;

    always_comb begin
        rd   = rq;
        take = 1'b0;
        unique case (rq.st)
            ST_IDLE: begin
                if (brk_en) begin
                    rd.st   = ST_BRK;
                    rd.line = 1'b0;
                end else if (start_ok) begin
                    rd.st   = ST_SEND;
                    rd.cnt  = '0;
                    rd.line = 1'b0;
                    rd.sh   = {1'b1, hold_data};
                    take    = 1'b1;
                end
            end
            ST_SEND: begin
                if (brk_en) begin
                    rd.st   = ST_BRK;
                    rd.line = 1'b0;
                end else if (baud_tick) begin
                    if (rq.cnt == LAST_BIT) begin
                        if (start_ok) begin
                            rd.cnt  = '0;
                            rd.line = 1'b0;
                            rd.sh   = {1'b1, hold_data};
                            take    = 1'b1;
                        end else begin
                            rd.st   = ST_IDLE;
                            rd.line = 1'b1;
                        end
                    end else begin
                        rd.cnt  = rq.cnt + 1'b1;
                        rd.line = rq.sh[0];
                        rd.sh   = {1'b1, rq.sh[DATA_W:1]};
                    end
                end
            end
            ST_BRK: begin
                rd.line = 1'b0;
                if (!brk_en) begin
                    rd.st   = ST_GAP;
                    rd.line = 1'b1;
                end
            end
            ST_GAP: begin
                rd.line = 1'b1;
                if (brk_en) begin
                    rd.st   = ST_BRK;
                    rd.line = 1'b0;
                end else if (baud_tick) begin
                    rd.st = ST_IDLE;
                end
            end
            default: rd.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq.st   <= ST_IDLE;
            rq.cnt  <= '0;
            rq.sh   <= '1;
            rq.line <= 1'b1;
        end else begin
            rq <= rd;
        end
    end

    assign tx_line = rq.line & ~brk_en;
    assign busy    = (rq.st == ST_SEND);
    assign dis_irq = dis_sts;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rq.st == ST_IDLE) |-> rq.line); // R1
    AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (rq.st != ST_SEND && tx_dis) |=> (rq.st != ST_SEND)); // R3
    AST_HELD_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && tx_dis && rq.st != ST_SEND) |=> hold_full); // R5
    AST_BREAK_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_en && $past(brk_en)) |-> !rq.line); // R7
    AST_BREAK_ABANDONS: assert property (@(posedge clk) disable iff (!rst_n)
        (rq.st == ST_SEND && brk_en) |=> !busy); // R8
    AST_GAP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rq.st == ST_GAP) |=> (rq.st != ST_SEND)); // R9
endmodule

// File: tb/uart_brk_tx_test.sv
module uart_brk_tx_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       brk_en = 1'b0;
    logic       tx_dis = 1'b0;
    logic       dis_clr = 1'b0;
    logic       tx_line, busy, hold_full, dis_sts, dis_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_brk_tx uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .brk_en(brk_en), .tx_dis(tx_dis), .dis_clr(dis_clr),
        .tx_line(tx_line), .busy(busy), .hold_full(hold_full),
        .dis_sts(dis_sts), .dis_irq(dis_irq)
    );

    // {data, expected line per tick: bit k = value after tick k} per R1
    localparam logic [17:0] VEC [5] = '{
        {8'hA5, 10'h34A},
        {8'h00, 10'h200},
        {8'hFF, 10'h3FE},
        {8'h3C, 10'h278},
        {8'h81, 10'h302}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic run_frame(input logic [9:0] pat, input string req);
        for (int k = 0; k < 10; k++) begin
            tick();
            chk(req, tx_line, pat[k]);
            chk("R2 busy in frame", busy, 1'b1);
        end
        tick();
        chk("R2 busy after stop", busy, 1'b0);
        chk(req, tx_line, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset line", tx_line, 1'b1);
        chk("R2 reset busy", busy, 1'b0);
        chk("R10 reset empty", hold_full, 1'b0);
        chk("R4 reset sts", dis_sts, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 table of frames
        for (int i = 0; i < 5; i++) begin
            wr(VEC[i][17:10]);
            chk("R10 write accepted", hold_full, 1'b1);
            run_frame(VEC[i][9:0], "R1 frame bit");
        end

        // R3 R4 R5 R10: disable mid-frame, queued byte held, extra write ignored
        wr(8'h5A);
        tick();
        chk("R1 start", tx_line, 1'b0);
        @(negedge clk) tx_dis = 1'b1;
        wr(8'hC3);
        wr(8'hEE);
        for (int k = 1; k < 10; k++) begin
            tick();
            chk("R3 frame completes", tx_line, (k == 9) ? 1'b1 : ((8'h5A >> (k - 1)) & 1'b1));
            chk("R4 not yet disabled", dis_sts, 1'b0);
        end
        tick();
        chk("R3 no new start", busy, 1'b0);
        @(negedge clk);
        chk("R4 sts set", dis_sts, 1'b1);
        chk("R4 irq", dis_irq, 1'b1);
        tick();
        tick();
        chk("R3 still idle", tx_line, 1'b1);
        chk("R5 byte kept", hold_full, 1'b1);

        // R7 break after disabled seen
        @(negedge clk) brk_en = 1'b1;
        #1 chk("R7 break same cycle", tx_line, 1'b0);
        tick();
        tick();
        chk("R7 break held", tx_line, 1'b0);
        @(negedge clk) brk_en = 1'b0;
        @(negedge clk);
        chk("R9 high after release", tx_line, 1'b1);
        tick();
        // R6 write-one-to-clear
        @(negedge clk) dis_clr = 1'b1;
        @(negedge clk) dis_clr = 1'b0;
        chk("R6 cleared", dis_sts, 1'b0);
        repeat (3) @(negedge clk);
        chk("R6 no re-set", dis_irq, 1'b0);
        @(negedge clk) tx_dis = 1'b0;
        // R5 resume with held byte (C3), not the ignored EE (R10)
        run_frame({1'b1, 8'hC3, 1'b0}, "R5 R10 resumed byte");
        chk("R5 emptied", hold_full, 1'b0);

        // R6 dropping tx_dis clears the flag
        @(negedge clk) tx_dis = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 idle disable sets", dis_sts, 1'b1);
        @(negedge clk) tx_dis = 1'b0;
        @(negedge clk);
        chk("R6 clear on drop", dis_sts, 1'b0);

        // R8 R9: break mid-frame
        wr(8'h96);
        tick();
        tick();
        tick();
        wr(8'h4B);
        @(negedge clk) brk_en = 1'b1;
        #1 chk("R7 mid-frame low", tx_line, 1'b0);
        @(negedge clk);
        chk("R8 abandoned", busy, 1'b0);
        tick();
        chk("R8 still low", tx_line, 1'b0);
        @(negedge clk) brk_en = 1'b0;
        @(negedge clk);
        chk("R9 high", tx_line, 1'b1);
        tick();
        chk("R9 no start on first tick", tx_line, 1'b1);
        chk("R9 not busy", busy, 1'b0);
        run_frame({1'b1, 8'h4B, 1'b0}, "R8 R9 next byte");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule